// File: doc/BRIEF.md
# Three-Wire Serial Register Bank

This block takes configuration words from a three-wire serial bus (data, serial clock, latch enable) and keeps them in a bank of seven control registers for a frequency synthesizer. Serial bits are collected in a 24-bit shift register. When latch enable rises, a variable-length address held in the low bits of the word chooses the destination register. The address codes form a prefix code, so no code is the start of another.

The bus pins are resynchronised into the system clock, and all edges are detected in that domain. The bank drives the decoded control fields, the effective IF divider counts and the gated RF and IF section enables. A default-select bit decides whether the IF counters come from parameters or from programmed registers. While that bit is set, writes to the IF counter registers and the test register are dropped. A chip-enable pin turns both sections off whatever the registers hold. A one-cycle strobe marks each update of the main divider register so that a downstream divider can reload.

Top module: `serial_reg_bank`

## Requirements
- R1: On each synchronised rising edge of `ser_clk`, `ser_dat` shifts into bit 0 of a 24-bit shift register and all older bits move up one place. The word is therefore sent most significant bit first. If more than 24 bits arrive before latch enable, only the last 24 are kept.
- R2: On a synchronised rising edge of `ser_le`, the shift register is written to the register that its low bits select. The codes are: main `xx00`, power `01`, pump `10`, loop `011`, IF-N `0111`, IF-R `01111`, test `011111`. A word ending in `111111` changes no register.
- R3: Main register fields: bit 23 is the default select, bit 22 the band select, bit 21 the lock-detect enable and bit 20 the spur control. B is at [19:16], A at [15:13] and FN at [12:2].
- R4: Power register fields: IF frequency select at [23:22], oscillator select at 21, spur mode at [12:11], output power at [5:4], RF enable at 3 and IF enable at 2.
- R5: The pump register field [23:22] gives `cp_current_ua`: 00 gives 100, 01 gives 200, 10 gives 300 and 11 gives 800.
- R6: Loop register fields: bandwidth duration at [23:22], bandwidth criterion at [21:20], bandwidth enable at 19 and VCO current at [4:3].
- R7: The IF-N register holds IF A at [16:13] and IF B at [12:4]. The IF-R register holds IF R at [13:5]. Writes to the IF-N, IF-R and test registers are discarded while the stored default-select bit is 1.
- R8: When the default select is 1, `if_a`, `if_b` and `if_r` equal the parameters DEF_IF_A, DEF_IF_B and DEF_IF_R. When it is 0, they equal the programmed values.
- R9: The test register stores and shows the whole 24-bit word, address bits included.
- R10: `rf_on` is RF enable AND `chip_en`, and `if_on` is IF enable AND `chip_en`. Both are low while `chip_en` is low, even if the registers are written during that time.
- R11: `r0_load` is high for exactly one cycle for each write to the main register. It rises in the same cycle that the new main fields appear. It stays low for writes to any other register, and the main fields do not change while it is low.
- R12: While `rst_n` is low, every register and the shift register clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial bus clock |
| ser_dat | input | 1 | Serial bus data |
| ser_le | input | 1 | Serial bus latch enable |
| chip_en | input | 1 | Chip enable, low turns both sections off |
| dflt_sel | output | 1 | Default-select bit for the IF counters |
| band_sel | output | 1 | Band select |
| lock_det_en | output | 1 | Lock-detect output enable |
| spur_ctl | output | 1 | Spur control bit |
| rf_b | output | 4 | RF B counter |
| rf_a | output | 3 | RF A (swallow) counter |
| rf_fn | output | 11 | RF fractional numerator |
| r0_load | output | 1 | One-cycle strobe on a main register write |
| if_freq_sel | output | 2 | IF frequency select |
| osc_sel | output | 1 | Reference oscillator select |
| spur_mode | output | 2 | Spur reduction mode |
| out_pwr | output | 2 | RF output power level |
| rf_on | output | 1 | RF section active |
| if_on | output | 1 | IF section active |
| if_cur | output | 2 | IF charge pump code |
| cp_current_ua | output | 10 | IF charge pump current in microamps |
| bw_dur | output | 2 | Bandwidth control duration |
| bw_crl | output | 2 | Bandwidth phase criterion |
| bw_en | output | 1 | Bandwidth control enable |
| vco_cur | output | 2 | VCO dynamic current |
| if_a | output | 4 | Effective IF A counter |
| if_b | output | 9 | Effective IF B counter |
| if_r | output | 9 | Effective IF R counter |
| test_word | output | 24 | Stored test register |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This shows that the edge detection and the latching still line up when the synchroniser is one stage deeper. The IF defaults are set to 4, 191 and 164, so they differ from the values the bench programs. This way a switch of the default-select bit is visible on `if_a`, `if_b` and `if_r`, and so is a write to the IF-N register that should have been dropped.

// File: rtl/serial_reg_bank.sv
module serial_reg_bank #(
  parameter int       SYNC_STAGES = 2,
  parameter int       WORD_W      = 24,
  parameter int       NUM_REGS    = 7,
  parameter bit [3:0] DEF_IF_A    = 4'd9,
  parameter bit [8:0] DEF_IF_B    = 9'd229,
  parameter bit [8:0] DEF_IF_R    = 9'd160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_le,
  input  logic        chip_en,
  output logic        dflt_sel,
  output logic        band_sel,
  output logic        lock_det_en,
  output logic        spur_ctl,
  output logic [3:0]  rf_b,
  output logic [2:0]  rf_a,
  output logic [10:0] rf_fn,
  output logic        r0_load,
  output logic [1:0]  if_freq_sel,
  output logic        osc_sel,
  output logic [1:0]  spur_mode,
  output logic [1:0]  out_pwr,
  output logic        rf_on,
  output logic        if_on,
  output logic [1:0]  if_cur,
  output logic [9:0]  cp_current_ua,
  output logic [1:0]  bw_dur,
  output logic [1:0]  bw_crl,
  output logic        bw_en,
  output logic [1:0]  vco_cur,
  output logic [3:0]  if_a,
  output logic [8:0]  if_b,
  output logic [8:0]  if_r,
  output logic [23:0] test_word
);
  localparam int GATED_FIRST = 4;

  logic [SYNC_STAGES-1:0] clk_sync, le_sync, dat_sync;
  logic                   clk_prev, le_prev;
  logic [WORD_W-1:0]      shreg;
  logic [WORD_W-1:0]      regs [NUM_REGS];
  logic [NUM_REGS-1:0]    hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      le_sync  <= '0;
      dat_sync <= '0;
      clk_prev <= 1'b0;
      le_prev  <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      le_sync  <= {le_sync[SYNC_STAGES-2:0], ser_le};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_dat};
      clk_prev <= clk_sync[SYNC_STAGES-1];
      le_prev  <= le_sync[SYNC_STAGES-1];
    end
  end

  wire shift_rise = clk_sync[SYNC_STAGES-1] & ~clk_prev;
  wire le_rise    = le_sync[SYNC_STAGES-1] & ~le_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (shift_rise) shreg <= {shreg[WORD_W-2:0], dat_sync[SYNC_STAGES-1]};
  end

  assign hit[0] = shreg[1:0] == 2'b00;
  assign hit[1] = shreg[1:0] == 2'b01;
  assign hit[2] = shreg[1:0] == 2'b10;
  assign hit[3] = shreg[2:0] == 3'b011;
  assign hit[4] = shreg[3:0] == 4'b0111;
  assign hit[5] = shreg[4:0] == 5'b01111;
  assign hit[6] = shreg[5:0] == 6'b011111;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      r0_load <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (le_rise && hit[i] && (i < GATED_FIRST || !regs[0][23]))
          regs[i] <= shreg;
      r0_load <= le_rise & hit[0];
    end
  end

  assign dflt_sel    = regs[0][23];
  assign band_sel    = regs[0][22];
  assign lock_det_en = regs[0][21];
  assign spur_ctl    = regs[0][20];
  assign rf_b        = regs[0][19:16];
  assign rf_a        = regs[0][15:13];
  assign rf_fn       = regs[0][12:2];

  assign if_freq_sel = regs[1][23:22];
  assign osc_sel     = regs[1][21];
  assign spur_mode   = regs[1][12:11];
  assign out_pwr     = regs[1][5:4];
  assign rf_on       = chip_en & regs[1][3];
  assign if_on       = chip_en & regs[1][2];

  assign if_cur = regs[2][23:22];
  always_comb begin
    case (if_cur)
      2'b00:   cp_current_ua = 10'd100;
      2'b01:   cp_current_ua = 10'd200;
      2'b10:   cp_current_ua = 10'd300;
      default: cp_current_ua = 10'd800;
    endcase
  end

  assign bw_dur  = regs[3][23:22];
  assign bw_crl  = regs[3][21:20];
  assign bw_en   = regs[3][19];
  assign vco_cur = regs[3][4:3];

  assign if_a      = dflt_sel ? DEF_IF_A : regs[4][16:13];
  assign if_b      = dflt_sel ? DEF_IF_B : regs[4][12:4];
  assign if_r      = dflt_sel ? DEF_IF_R : regs[5][13:5];
  assign test_word = regs[6];
endmodule

// File: rtl/serial_reg_bank_chk.sv
module serial_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chip_en,
  input logic        rf_on,
  input logic        if_on,
  input logic        r0_load,
  input logic        dflt_sel,
  input logic        band_sel,
  input logic        lock_det_en,
  input logic        spur_ctl,
  input logic [3:0]  rf_b,
  input logic [2:0]  rf_a,
  input logic [10:0] rf_fn,
  input logic [9:0]  cp_current_ua,
  input logic [23:0] test_word
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    r0_load |=> !r0_load); // R11
  AST_MAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !r0_load |-> $stable({dflt_sel, band_sel, lock_det_en, spur_ctl, rf_b, rf_a, rf_fn})); // R11
  AST_CHIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> !(rf_on || if_on)); // R10
  AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_sel && $past(dflt_sel)) |-> $stable(test_word)); // R7
  AST_PUMP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cp_current_ua inside {10'd100, 10'd200, 10'd300, 10'd800}); // R5
endmodule

bind serial_reg_bank serial_reg_bank_chk u_chk (.*);

// File: tb/serial_reg_bank_test.sv
`timescale 1ns/1ps
module serial_reg_bank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic dflt_sel, band_sel, lock_det_en, spur_ctl, r0_load, osc_sel, rf_on, if_on, bw_en;
  logic [3:0] rf_b, if_a;
  logic [2:0] rf_a;
  logic [10:0] rf_fn;
  logic [1:0] if_freq_sel, spur_mode, out_pwr, if_cur, bw_dur, bw_crl, vco_cur;
  logic [9:0] cp_current_ua;
  logic [8:0] if_b, if_r;
  logic [23:0] test_word;
  int n_checks = 0, n_fails = 0, pulses = 0;

  always #2 clk = ~clk;

  serial_reg_bank #(.SYNC_STAGES(3), .DEF_IF_A(4'd4), .DEF_IF_B(9'd191), .DEF_IF_R(9'd164)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .chip_en(chip_en), .dflt_sel(dflt_sel), .band_sel(band_sel), .lock_det_en(lock_det_en),
    .spur_ctl(spur_ctl), .rf_b(rf_b), .rf_a(rf_a), .rf_fn(rf_fn), .r0_load(r0_load),
    .if_freq_sel(if_freq_sel), .osc_sel(osc_sel), .spur_mode(spur_mode), .out_pwr(out_pwr),
    .rf_on(rf_on), .if_on(if_on), .if_cur(if_cur), .cp_current_ua(cp_current_ua),
    .bw_dur(bw_dur), .bw_crl(bw_crl), .bw_en(bw_en), .vco_cur(vco_cur),
    .if_a(if_a), .if_b(if_b), .if_r(if_r), .test_word(test_word));

  always @(negedge clk) if (r0_load) pulses++;

  // word[55:32], observation select[31:24], expected[23:0]
  localparam logic [55:0] VEC [14] = '{
    {{2'b10,1'b1,8'h80,2'b10,5'b00101,2'b11,1'b1,1'b0,2'b01}, 8'd1, {15'd0,2'b10,1'b1,2'b10,2'b11,1'b1,1'b0}},
    {{1'b0,1'b1,1'b1,1'b0,4'd11,3'd4,11'd1104,2'b00}, 8'd0, {2'b00,1'b0,1'b1,1'b1,1'b0,4'd11,3'd4,11'd1104}},
    {{2'b11,20'h5A5A5,2'b10}, 8'd2, {12'd0,2'b11,10'd800}},
    {{2'b01,20'h00000,2'b10}, 8'd2, {12'd0,2'b01,10'd200}},
    {{2'b10,20'hFFFFF,2'b10}, 8'd2, {12'd0,2'b10,10'd300}},
    {{2'b01,2'b10,1'b1,14'h2F46,2'b11,3'b011}, 8'd3, {17'd0,2'b01,2'b10,1'b1,2'b11}},
    {{7'd0,4'd9,9'd229,4'b0111}, 8'd4, {2'b00,4'd9,9'd229,9'd0}},
    {{10'd0,9'd160,5'b01111}, 8'd4, {2'b00,4'd9,9'd229,9'd160}},
    {{18'h2AAAA,6'b011111}, 8'd5, {18'h2AAAA,6'b011111}},
    {{18'h15555,6'b111111}, 8'd5, {18'h2AAAA,6'b011111}},
    {{1'b1,1'b0,1'b0,1'b0,4'd2,3'd0,11'd0,2'b00}, 8'd4, {2'b00,4'd4,9'd191,9'd164}},
    {{7'd0,4'd3,9'd100,4'b0111}, 8'd4, {2'b00,4'd4,9'd191,9'd164}},
    {{1'b0,1'b0,1'b0,1'b1,4'd5,3'd1,11'd7,2'b00}, 8'd4, {2'b00,4'd9,9'd229,9'd160}},
    {{2'b00,1'b0,8'h80,2'b11,5'b00101,2'b00,1'b0,1'b1,2'b01}, 8'd1, {15'd0,2'b00,1'b0,2'b11,2'b00,1'b0,1'b1}}
  };

  function automatic logic [23:0] obs(input int s);
    case (s)
      0: return {2'b00, dflt_sel, band_sel, lock_det_en, spur_ctl, rf_b, rf_a, rf_fn};
      1: return {15'd0, if_freq_sel, osc_sel, spur_mode, out_pwr, rf_on, if_on};
      2: return {12'd0, if_cur, cp_current_ua};
      3: return {17'd0, bw_dur, bw_crl, bw_en, vco_cur};
      4: return {2'b00, if_a, if_b, if_r};
      default: return test_word;
    endcase
  endfunction

  function automatic string tag(input int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7/R8";
      default: return "R9/R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int nb);
    ser_le = 1'b0;
    for (int i = nb - 1; i >= 0; i--) begin
      ser_dat = w[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(6);
      ser_clk = 1'b0;
      wait_clk(2);
    end
    wait_clk(4);
    ser_le = 1'b1;
    wait_clk(10);
    ser_le = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired before the run ended");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    wait_clk(5);
    // R12: reset state
    for (int s = 0; s < 6; s++)
      check("R12", obs(s), (s == 2) ? {12'd0, 2'b00, 10'd100} : 24'd0);
    check("R12 strobe", {23'd0, r0_load}, 24'd0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1/R2: vector table, each word shifted MSB first and latched
    for (int v = 0; v < 14; v++) begin
      send_bits({8'd0, VEC[v][55:32]}, 24);
      check(tag(int'(VEC[v][31:24])), obs(int'(VEC[v][31:24])), VEC[v][23:0]);
    end

    // R10: chip enable gating
    chip_en = 1'b0;
    wait_clk(1);
    check("R10 off", {22'd0, rf_on, if_on}, 24'd0);
    send_bits({8'd0, 2'b00,1'b0,8'h80,2'b10,5'b00101,2'b00,1'b1,1'b1,2'b01}, 24);
    check("R10 write while off", {22'd0, rf_on, if_on}, 24'd0);
    chip_en = 1'b1;
    wait_clk(1);
    check("R10 on", {22'd0, rf_on, if_on}, {22'd0, 2'b11});

    // R11: strobe count for a main write and for a non-main write
    pulses = 0;
    send_bits({8'd0, 1'b0,1'b1,1'b0,1'b1,4'd7,3'd3,11'd1500,2'b00}, 24);
    check("R11 main write", 24'(pulses), 24'd1);
    check("R3 fields", obs(0), {2'b00,1'b0,1'b1,1'b0,1'b1,4'd7,3'd3,11'd1500});
    pulses = 0;
    send_bits({8'd0, 2'b11,20'h0,2'b10}, 24);
    check("R11 other write", 24'(pulses), 24'd0);

    // R1: extra leading bits are pushed out, the last 24 are kept
    send_bits({2'b00, 6'h3F, 1'b0,1'b0,1'b1,1'b0,4'd15,3'd7,11'd1967,2'b00}, 30);
    check("R1 overlong", obs(0), {2'b00,1'b0,1'b0,1'b1,1'b0,4'd15,3'd7,11'd1967});

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule